// File: doc/BRIEF.md
# Level Interrupt Notification Generator

This block sits between a set of level-sensitive interrupt sources and the memory fabric. It keeps a small bank of 64-bit configuration registers and a level word that records which sources are currently asserted. When the event logic upstream asks it to notify for a given source, the block builds a 64-bit logical interrupt number and hands one big-endian memory write to a bus master through a valid/ready handshake. The logical number is a table offset plus the source number. The write goes to the programmed notification address.

Configuration and status are reached through a byte-addressed register port with combinational read data. A separate sideband port can only program the base of the block's own register window. A small queue holds notifications that arrive while the bus master is stalled, so source events that come back to back are kept.

Top module: `lvl_notify_gen`

## Requirements
- R1: After reset, the control, event-page, notification-address, table-offset and level registers all read zero. The page window is off, `wr_valid` is low, `notify_ready` is high, and `bridge_base` equals the reset base with bit 0 set.
- R2: The register port decodes these byte offsets: control 0x58, event-page base 0x60, notification address 0x68, table offset 0x70, level 0x78. The level register is read-only. A read of any other offset returns all ones, and a write to any other offset has no effect.
- R3: An accepted source event for source n with state 1 sets bit (63 - n) of the level register. State 0 clears that bit. Other bits keep their values.
- R4: While control bit 63 (method bit) is set, source events are rejected and the level register is unchanged. `ev_err` is high for exactly the cycle after the rejected event.
- R5: A control write with bit 62 set clears the level register and stores the written value. `src_reset` is high for the cycle after that write.
- R6: On a write to 0x60 that takes bit 0 from 0 to 1, the page window turns on at the written value with bit 0 cleared. A write that takes bit 0 from 1 to 0 turns it off. A write that keeps bit 0 at 1 updates the register but keeps the window address.
- R7: A notification for source s carries the value (offset[63:32] + s) mod 2^32, zero-extended to 64 bits. It is sent to the notification register with bit 0 cleared. `wr_data` carries the value big-endian: bits 7:0 hold the most significant byte.
- R8: When bit 0 of the notification address register is clear, a notify request produces no write.
- R9: Up to DEPTH notifications are queued and written in request order. `notify_ready` is low while the queue is full. While `wr_valid` is high and `wr_ready` is low, `wr_addr` and `wr_data` hold steady.
- R10: A sideband write to index 0x0A stores the data ANDed with the base mask plus bit 0 into `bridge_base`. Sideband writes to any other index are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register port write strobe |
| reg_addr | input | 8 | Register byte offset (read and write) |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Combinational read data for `reg_addr` |
| sb_wr_en | input | 1 | Sideband write strobe |
| sb_index | input | 6 | Sideband register index |
| sb_wdata | input | 64 | Sideband write data |
| bridge_base | output | 64 | Programmed register-window base with enable in bit 0 |
| ev_valid | input | 1 | Source level event strobe |
| ev_src | input | SRC_W | Source number of the event |
| ev_state | input | 1 | New level of the source |
| ev_err | output | 1 | Pulse: event rejected by the method bit |
| src_reset | output | 1 | Pulse: source state reset requested |
| page_win_en | output | 1 | Event-page window enabled |
| page_win_addr | output | 64 | Event-page window base address |
| notify_req | input | 1 | Notification request |
| notify_src | input | SRC_W | Source number to notify |
| notify_ready | output | 1 | Queue can accept a request |
| wr_valid | output | 1 | Memory write request valid |
| wr_addr | output | 64 | Memory write address |
| wr_data | output | 64 | Memory write data, big-endian byte order |
| wr_ready | input | 1 | Bus master accepts the write |

## Verification
The notification path is driven three ways: a single request with the bus master ready, four back-to-back requests against a stalled bus master, and a request whose offset sum wraps past 32 bits. These separate a wrong byte order or address mask, lost or reordered queue entries, and an adder that is wider or narrower than 32 bits. Level tracking is exercised on the lowest and highest source, with the method bit both clear and set. The event-page base is written through all three bit-0 transitions, so a window that follows the register on every write shows up as a mismatch.

// File: rtl/lnotif_pkg.sv
// Package: shared offsets, bit positions and the queued write item for the
// level interrupt notification generator. Assumes 64-bit registers.
package lnotif_pkg;
    localparam logic [7:0] OFF_CTRL  = 8'h58;
    localparam logic [7:0] OFF_PAGE  = 8'h60;
    localparam logic [7:0] OFF_NADDR = 8'h68;
    localparam logic [7:0] OFF_TOFS  = 8'h70;
    localparam logic [7:0] OFF_LEVEL = 8'h78;
    localparam logic [5:0] SB_BASE_IDX = 6'h0A;

    localparam int CTRL_METHOD_BIT = 63;
    localparam int CTRL_RESET_BIT  = 62;

    typedef struct packed {
        logic [63:0] addr;
        logic [63:0] data;
    } wr_item_t;

    // Reorders the eight bytes so the most significant byte lands in lane 0.
    function automatic logic [63:0] to_big_endian(input logic [63:0] v);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) begin
            r[8*i +: 8] = v[8*(7-i) +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/lnotif_regs.sv
// Module: register bank, level tracking, page window and sideband base.
// Assumes single-cycle register writes and combinational read data.
module lnotif_regs #(
    parameter int          NUM_SRC      = 14,
    parameter int          SRC_W        = 4,
    parameter logic [63:0] BRIDGE_RESET = 64'h0006_0302_0310_0000,
    parameter logic [63:0] BRIDGE_MASK  = 64'h00FF_FFFF_FFF0_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [7:0]       reg_addr,
    input  logic [63:0]      reg_wdata,
    output logic [63:0]      reg_rdata,
    input  logic             sb_wr_en,
    input  logic [5:0]       sb_index,
    input  logic [63:0]      sb_wdata,
    output logic [63:0]      bridge_base,
    input  logic             ev_valid,
    input  logic [SRC_W-1:0] ev_src,
    input  logic             ev_state,
    output logic             ev_err,
    output logic             src_reset,
    output logic             page_win_en,
    output logic [63:0]      page_win_addr,
    output logic [63:0]      notif_q,
    output logic [31:0]      tofs_hi
);
    import lnotif_pkg::*;

    localparam logic [63:0] BRIDGE_KEEP = BRIDGE_MASK | 64'h1;

    logic [63:0] ctrl_q, page_q, naddr_q, tofs_q, bridge_q;
    logic [63:0] win_addr_q;
    logic        ev_err_q, src_reset_q;
    logic [NUM_SRC-1:0] lvl_bits;
    logic [63:0] level_word;

    logic wr_ctrl, wr_page, src_clr, ev_accept;

    // Decode of the register writes that have side effects.
    always_comb begin
        wr_ctrl   = reg_wr_en && (reg_addr == OFF_CTRL);
        wr_page   = reg_wr_en && (reg_addr == OFF_PAGE);
        src_clr   = wr_ctrl && reg_wdata[CTRL_RESET_BIT];
        ev_accept = ev_valid && !ctrl_q[CTRL_METHOD_BIT];
    end

    // Plain storage registers written from the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            naddr_q <= '0;
            tofs_q  <= '0;
        end else if (reg_wr_en) begin
            if (reg_addr == OFF_CTRL)  ctrl_q  <= reg_wdata;
            if (reg_addr == OFF_NADDR) naddr_q <= reg_wdata;
            if (reg_addr == OFF_TOFS)  tofs_q  <= reg_wdata;
        end
    end

    // Event-page base; the window address follows only an enabling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q     <= '0;
            win_addr_q <= '0;
        end else if (wr_page) begin
            page_q <= reg_wdata;
            if (reg_wdata[0] && !page_q[0]) begin
                win_addr_q <= {reg_wdata[63:1], 1'b0};
            end
        end
    end

    // Sideband port: only the window base index is writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bridge_q <= BRIDGE_RESET | 64'h1;
        end else if (sb_wr_en && sb_index == SB_BASE_IDX) begin
            bridge_q <= sb_wdata & BRIDGE_KEEP;
        end
    end

    // One-cycle status pulses for rejected events and source reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_err_q    <= 1'b0;
            src_reset_q <= 1'b0;
        end else begin
            ev_err_q    <= ev_valid && ctrl_q[CTRL_METHOD_BIT];
            src_reset_q <= src_clr;
        end
    end

    // One level flop per source; source reset wins over a same-cycle event.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_level
        always_ff @(posedge clk) begin
            if (!rst_n || src_clr) begin
                lvl_bits[g] <= 1'b0;
            end else if (ev_accept && ev_src == SRC_W'(g)) begin
                lvl_bits[g] <= ev_state;
            end
        end
    end

    // Place source n at bit (63 - n) of the level word.
    always_comb begin
        level_word = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            level_word[63-i] = lvl_bits[i];
        end
    end

    // Read mux; unmapped offsets return all ones.
    always_comb begin
        case (reg_addr)
            OFF_CTRL:  reg_rdata = ctrl_q;
            OFF_PAGE:  reg_rdata = page_q;
            OFF_NADDR: reg_rdata = naddr_q;
            OFF_TOFS:  reg_rdata = tofs_q;
            OFF_LEVEL: reg_rdata = level_word;
            default:   reg_rdata = '1;
        endcase
    end

    assign bridge_base   = bridge_q;
    assign ev_err        = ev_err_q;
    assign src_reset     = src_reset_q;
    assign page_win_en   = page_q[0];
    assign page_win_addr = win_addr_q;
    assign notif_q       = naddr_q;
    assign tofs_hi       = tofs_q[63:32];

    // R4: a rejected event leaves the level word alone and raises the error pulse.
    assert_reject_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ctrl_q[CTRL_METHOD_BIT] && !src_clr) |=> ($stable(level_word) && ev_err));

    // R5: while the source-reset pulse is out, the level word is empty.
    assert_reset_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        src_reset |-> (level_word == 64'h0));

    // R6: an open window never moves its address.
    assert_window_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (page_win_en && $past(page_win_en)) |-> (page_win_addr == $past(page_win_addr)));
endmodule

// File: rtl/lnotif_fifo.sv
// Module: small synchronous FIFO for pending notification writes.
// Assumes the writer never pushes while full; head data is combinational.
module lnotif_fifo #(
    parameter int WIDTH = 128,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    // Pointer advance with wrap for any depth.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write; no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assign head  = mem[rd_ptr];
    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);

    // R9: the writer side never pushes into a full queue.
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R9: nothing is popped from an empty queue.
    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/lvl_notify_gen.sv
// Module: top of the level interrupt notification generator. Builds the
// notification item from the current registers and queues it for the bus
// master. Assumes the requester holds a request until notify_ready is high.
module lvl_notify_gen #(
    parameter int          NUM_SRC      = 14,
    parameter int          DEPTH        = 4,
    parameter logic [63:0] BRIDGE_RESET = 64'h0006_0302_0310_0000,
    parameter logic [63:0] BRIDGE_MASK  = 64'h00FF_FFFF_FFF0_0000,
    localparam int         SRC_W        = $clog2(NUM_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [7:0]       reg_addr,
    input  logic [63:0]      reg_wdata,
    output logic [63:0]      reg_rdata,
    input  logic             sb_wr_en,
    input  logic [5:0]       sb_index,
    input  logic [63:0]      sb_wdata,
    output logic [63:0]      bridge_base,
    input  logic             ev_valid,
    input  logic [SRC_W-1:0] ev_src,
    input  logic             ev_state,
    output logic             ev_err,
    output logic             src_reset,
    output logic             page_win_en,
    output logic [63:0]      page_win_addr,
    input  logic             notify_req,
    input  logic [SRC_W-1:0] notify_src,
    output logic             notify_ready,
    output logic             wr_valid,
    output logic [63:0]      wr_addr,
    output logic [63:0]      wr_data,
    input  logic             wr_ready
);
    import lnotif_pkg::*;

    localparam int ITEM_W = $bits(wr_item_t);

    logic [63:0] notif_q;
    logic [31:0] tofs_hi;
    logic [31:0] lisn;
    wr_item_t    new_item, head_item;
    logic        push, pop, q_full, q_empty;

    lnotif_regs #(
        .NUM_SRC      (NUM_SRC),
        .SRC_W        (SRC_W),
        .BRIDGE_RESET (BRIDGE_RESET),
        .BRIDGE_MASK  (BRIDGE_MASK)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr_en     (reg_wr_en),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .sb_wr_en      (sb_wr_en),
        .sb_index      (sb_index),
        .sb_wdata      (sb_wdata),
        .bridge_base   (bridge_base),
        .ev_valid      (ev_valid),
        .ev_src        (ev_src),
        .ev_state      (ev_state),
        .ev_err        (ev_err),
        .src_reset     (src_reset),
        .page_win_en   (page_win_en),
        .page_win_addr (page_win_addr),
        .notif_q       (notif_q),
        .tofs_hi       (tofs_hi)
    );

    // Build the queued item: 32-bit logical number, big-endian, aligned address.
    always_comb begin
        lisn          = tofs_hi + 32'(notify_src);
        new_item.addr = {notif_q[63:1], 1'b0};
        new_item.data = to_big_endian({32'h0, lisn});
        push          = notify_req && !q_full && notif_q[0];
        pop           = !q_empty && wr_ready;
    end

    lnotif_fifo #(
        .WIDTH (ITEM_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (new_item),
        .pop       (pop),
        .head      (head_item),
        .full      (q_full),
        .empty     (q_empty)
    );

    assign notify_ready = !q_full;
    assign wr_valid     = !q_empty;
    assign wr_addr      = head_item.addr;
    assign wr_data      = head_item.data;

    // R9: a stalled write keeps its address and data.
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R7: every issued write targets an address with bit 0 clear.
    assert_addr_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !wr_addr[0]);
endmodule

// File: tb/lvl_notify_gen_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected writes, a monitor pops them.
module lvl_notify_gen_bench;
    localparam int NUM_SRC = 14;
    localparam int SRC_W   = 4;
    localparam logic [63:0] B_RESET = 64'h0006_0302_0310_0000;
    localparam logic [63:0] B_MASK  = 64'h00FF_FFFF_FFF0_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic sb_wr_en = 1'b0;
    logic [5:0]  sb_index = '0;
    logic [63:0] sb_wdata = '0;
    logic [63:0] bridge_base;
    logic ev_valid = 1'b0;
    logic [SRC_W-1:0] ev_src = '0;
    logic ev_state = 1'b0;
    logic ev_err, src_reset, page_win_en;
    logic [63:0] page_win_addr;
    logic notify_req = 1'b0;
    logic [SRC_W-1:0] notify_src = '0;
    logic notify_ready, wr_valid;
    logic [63:0] wr_addr, wr_data;
    logic wr_ready = 1'b1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [127:0] exp_q[$];
    logic [63:0] m_naddr = '0;
    logic [31:0] m_tofs  = '0;

    always #2.5 clk = ~clk;

    lvl_notify_gen u_lvl_notify_gen (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sb_wr_en(sb_wr_en), .sb_index(sb_index), .sb_wdata(sb_wdata), .bridge_base(bridge_base),
        .ev_valid(ev_valid), .ev_src(ev_src), .ev_state(ev_state), .ev_err(ev_err),
        .src_reset(src_reset), .page_win_en(page_win_en), .page_win_addr(page_win_addr),
        .notify_req(notify_req), .notify_src(notify_src), .notify_ready(notify_ready),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_read(input logic [7:0] a, input logic [63:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [63:0] d);
        @(posedge clk); #1;
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        if (a == 8'h68) m_naddr = d;
        if (a == 8'h70) m_tofs = d[63:32];
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
    endtask

    task automatic send_ev(input int s, input logic st);
        @(posedge clk); #1;
        ev_valid = 1'b1; ev_src = SRC_W'(s); ev_state = st;
        @(posedge clk); #1;
        ev_valid = 1'b0;
    endtask

    task automatic sb_write(input logic [5:0] idx, input logic [63:0] d);
        @(posedge clk); #1;
        sb_wr_en = 1'b1; sb_index = idx; sb_wdata = d;
        @(posedge clk); #1;
        sb_wr_en = 1'b0;
    endtask

    function automatic logic [63:0] swap_bytes(input logic [63:0] v);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[63-8*i -: 8] = v[8*i +: 8];
        return r;
    endfunction

    // Holds the request for one cycle and records the expected write (R7, R8).
    task automatic notify_pulse(input int s);
        logic [31:0] n;
        @(posedge clk); #1;
        notify_req = 1'b1; notify_src = SRC_W'(s);
        if (m_naddr[0]) begin
            n = m_tofs + 32'(s);
            exp_q.push_back({m_naddr & ~64'h1, swap_bytes({32'h0, n})});
        end
    endtask

    task automatic notify_end();
        @(posedge clk); #1;
        notify_req = 1'b0;
    endtask

    // Monitor: every handshake must match the oldest expected write (R7, R9).
    always @(negedge clk) begin
        if (rst_n && wr_valid && wr_ready) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R8: actual write %h/%h expected none", wr_addr, wr_data);
            end else begin
                logic [127:0] e;
                e = exp_q.pop_front();
                if ({wr_addr, wr_data} !== e) begin
                    errors++;
                    $display("FAIL R7: actual %h expected %h", {wr_addr, wr_data}, e);
                end
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        logic [63:0] a0, d0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        chk_read(8'h58, 64'h0, "R1 ctrl");
        chk_read(8'h78, 64'h0, "R1 level");
        chk_read(8'h68, 64'h0, "R1 notify addr");
        chk("R1 bridge_base", bridge_base, B_RESET | 64'h1);
        chk("R1 page_win_en", {63'h0, page_win_en}, 64'h0);
        chk("R1 wr_valid", {63'h0, wr_valid}, 64'h0);
        chk("R1 notify_ready", {63'h0, notify_ready}, 64'h1);

        // R2: read-back, read-only level, unmapped offsets
        reg_write(8'h70, 64'h1000_0000_0000_DEAD);
        chk_read(8'h70, 64'h1000_0000_0000_DEAD, "R2 offset readback");
        reg_write(8'h78, 64'hFFFF_FFFF_FFFF_FFFF);
        chk_read(8'h78, 64'h0, "R2 level write ignored");
        reg_write(8'h20, 64'h0);
        chk_read(8'h20, 64'hFFFF_FFFF_FFFF_FFFF, "R2 unmapped read");

        // R3: level tracking on lowest and highest source
        send_ev(0, 1'b1);
        chk_read(8'h78, 64'h8000_0000_0000_0000, "R3 src0 set");
        send_ev(13, 1'b1);
        chk_read(8'h78, 64'h8004_0000_0000_0000, "R3 src13 set");
        send_ev(0, 1'b0);
        chk_read(8'h78, 64'h0004_0000_0000_0000, "R3 src0 clear");

        // R4: method bit rejects events
        reg_write(8'h58, 64'h8000_0000_0000_0000);
        send_ev(5, 1'b1);
        @(negedge clk);
        chk("R4 ev_err pulse", {63'h0, ev_err}, 64'h1);
        chk_read(8'h78, 64'h0004_0000_0000_0000, "R4 level unchanged");
        chk("R4 ev_err drops", {63'h0, ev_err}, 64'h0);

        // R5: source reset via control write
        reg_write(8'h58, 64'h4000_0000_0000_0000);
        @(negedge clk);
        chk("R5 src_reset pulse", {63'h0, src_reset}, 64'h1);
        chk_read(8'h78, 64'h0, "R5 level cleared");
        chk_read(8'h58, 64'h4000_0000_0000_0000, "R5 value stored");

        // R6: page window transitions
        reg_write(8'h60, 64'h0000_0000_1234_5001);
        @(negedge clk);
        chk("R6 window on", {63'h0, page_win_en}, 64'h1);
        chk("R6 window addr", page_win_addr, 64'h0000_0000_1234_5000);
        reg_write(8'h60, 64'h0000_0000_AAAA_0001);
        @(negedge clk);
        chk("R6 window addr kept", page_win_addr, 64'h0000_0000_1234_5000);
        chk_read(8'h60, 64'h0000_0000_AAAA_0001, "R6 register updated");
        reg_write(8'h60, 64'h0);
        @(negedge clk);
        chk("R6 window off", {63'h0, page_win_en}, 64'h0);

        // R8: no write while the valid flag is clear
        notify_pulse(3);
        notify_end();
        repeat (5) @(negedge clk);
        chk("R8 no write", {63'h0, wr_valid}, 64'h0);

        // R7: single notification
        reg_write(8'h68, 64'h8000_0000_0000_1001);
        reg_write(8'h70, 64'h1000_0000_0000_0000);
        notify_pulse(3);
        notify_end();
        repeat (4) @(negedge clk);
        chk("R7 queue drained", 64'(exp_q.size()), 64'h0);

        // R9: stalled bus master, back-to-back requests, full queue
        @(posedge clk); #1 wr_ready = 1'b0;
        notify_pulse(0);
        notify_pulse(1);
        notify_pulse(2);
        notify_pulse(13);
        notify_end();
        @(negedge clk);
        chk("R9 full", {63'h0, notify_ready}, 64'h0);
        a0 = wr_addr; d0 = wr_data;
        repeat (3) @(negedge clk);
        chk("R9 addr held", wr_addr, a0);
        chk("R9 data held", wr_data, d0);
        @(posedge clk); #1 wr_ready = 1'b1;
        repeat (8) @(negedge clk);
        chk("R9 all written in order", 64'(exp_q.size()), 64'h0);

        // R7: 32-bit wrap of the logical number
        reg_write(8'h70, 64'hFFFF_FFFF_0000_0000);
        notify_pulse(1);
        notify_end();
        repeat (4) @(negedge clk);
        chk("R7 wrap drained", 64'(exp_q.size()), 64'h0);

        // R10: sideband base
        sb_write(6'h0B, 64'h0);
        @(negedge clk);
        chk("R10 other index ignored", bridge_base, B_RESET | 64'h1);
        sb_write(6'h0A, 64'hFFFF_FFFF_FFFF_FFFE);
        @(negedge clk);
        chk("R10 masked base", bridge_base, 64'hFFFF_FFFF_FFFF_FFFE & (B_MASK | 64'h1));

        done = 1'b1;
        finish_run();
    end
endmodule